// File: doc/BRIEF.md
# EDID Block Fetch Sequencer

This block reads one 128-byte display-identification block through a byte-level DDC engine and checks it. A one-cycle `start` pulse carries a block number. The sequencer turns the block into a series of engine commands of at most 16 bytes each. For every command it clears the engine's receive FIFO, issues the command with a segment and word offset, waits for the engine's completion pulse, and pops the returned bytes into a local 128-byte store. Once the whole block is in the store it checks the block checksum. A timed-out command or a bad checksum restarts the whole block, up to a fixed number of extra attempts. `done` then pulses, and `err` reports whether the last attempt also failed.

The bit-level I2C engine sits outside this block. It is seen as a request/response port: a command strobe with segment, offset and length, a completion pulse, and a show-ahead FIFO with a pop strobe. The stored bytes are read back through an asynchronous read port.

States: IDLE (waits for `start`), CLEAR (FIFO clear), ISSUE (command strobe), WAIT (completion or timeout), DRAIN (one pop per cycle), CHECK (checksum test), RETRY (attempt bookkeeping), DONE (one-cycle completion). Transitions: IDLE→CLEAR on an accepted start; CLEAR→ISSUE→WAIT always; WAIT→DRAIN on completion; WAIT→RETRY on timeout; DRAIN→CLEAR after a command's last byte when bytes remain; DRAIN→CHECK after the block's last byte; CHECK→DONE when the sum is zero; CHECK→RETRY otherwise; RETRY→CLEAR while attempts remain; RETRY→DONE when they are used up; DONE→IDLE always.

Top module: `edid_fetch_seq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `eng_clr`, `eng_go` and `eng_pop` are all 0.
- R2: Each command has a length of min(16, bytes still missing in the block). A full 128-byte block therefore takes 8 commands of length 16.
- R3: The command for byte position p of block b addresses A = b*128 + p. `eng_seg` = A >> 8 and `eng_off` = A mod 256. Positions go 0, 16, ..., 112, in that order.
- R4: `eng_clr` is high for exactly the cycle before every `eng_go` cycle.
- R5: The bytes popped after a command are stored at positions p, p+1, ... and can be read on `rd_data` at `rd_addr`.
- R6: When the 8-bit sum of all 128 stored bytes is 0 mod 256, `done` pulses with `err` = 0.
- R7: On a nonzero sum the whole block is read again from position 0. After 1 + MAX_RETRY (= 3) failed attempts `done` pulses with `err` = 1.
- R8: A command whose completion is not seen within TO = CLK_HZ/1000*TIMEOUT_MS cycles after issue fails the attempt and is retried as in R7. Completion seen in WAIT cycle TO (the last one) is accepted; completion one cycle later is not.
- R9: A `start` that arrives while `busy` = 1 is ignored. The running fetch keeps its block number, and no second `done` follows.
- R10: Each accepted start produces exactly one one-cycle `done` pulse, after which `busy` returns to 0.
- R11: The number of pops per successful command equals its length. A timed-out command causes no pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| blk_idx | input | BLK_W | Block number to fetch |
| busy | output | 1 | High from an accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag of the last fetch, valid with done and held |
| eng_clr | output | 1 | Engine receive-FIFO clear strobe |
| eng_go | output | 1 | Engine command strobe |
| eng_seg | output | 8 | Command segment (address >> 8) |
| eng_off | output | 8 | Command word offset (address mod 256) |
| eng_len | output | clog2(BURST_MAX+1) | Command byte count |
| eng_done | input | 1 | Engine completion pulse |
| eng_rdata | input | 8 | FIFO head byte (show-ahead) |
| eng_pop | output | 1 | FIFO pop strobe |
| rd_addr | input | clog2(BLOCK_BYTES) | Store read address |
| rd_data | output | 8 | Store read data, combinational |

## Verification
A wrong position counter shows up on `eng_seg`/`eng_off` at the next command strobe, at most 22 cycles later in a normal burst, and in the read-back store. A mishandled attempt or retry counter shows up as the wrong number of commands and pops once `done` arrives, and as a wrong `err` value. Checksum faults are caught at the end of the block through `err` and the retry count. Timer faults are caught by engine delays placed exactly on and just past the timeout limit.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ISSUE,
        ST_WAIT,
        ST_DRAIN,
        ST_CHECK,
        ST_RETRY,
        ST_DONE
    } fetch_state_e;
endpackage

// File: rtl/edid_fetch_timer.sv
module edid_fetch_timer #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/edid_fetch_store.sv
module edid_fetch_store #(
    parameter int DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sum_clr,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [7:0]               rd_data,
    output logic                     sum_zero
);
    logic [7:0] mem [DEPTH];
    logic [7:0] sum_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || sum_clr) begin
            sum_q <= '0;
        end else if (wr_en) begin
            sum_q <= sum_q + wr_data;
        end
    end

    assign rd_data  = mem[rd_addr];
    assign sum_zero = (sum_q == 8'd0);
endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
    import edid_fetch_pkg::*;
#(
    parameter int BLK_W       = 8,
    parameter int BLOCK_BYTES = 128,
    parameter int BURST_MAX   = 16,
    parameter int MAX_RETRY   = 2,
    parameter int CLK_HZ      = 100_000_000,
    parameter int TIMEOUT_MS  = 200
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [BLK_W-1:0]                   blk_idx,
    output logic                               busy,
    output logic                               done,
    output logic                               err,
    output logic                               eng_clr,
    output logic                               eng_go,
    output logic [7:0]                         eng_seg,
    output logic [7:0]                         eng_off,
    output logic [$clog2(BURST_MAX+1)-1:0]     eng_len,
    input  logic                               eng_done,
    input  logic [7:0]                         eng_rdata,
    output logic                               eng_pop,
    input  logic [$clog2(BLOCK_BYTES)-1:0]     rd_addr,
    output logic [7:0]                         rd_data
);
    localparam int LEN_W  = $clog2(BURST_MAX + 1);
    localparam int POS_W  = $clog2(BLOCK_BYTES + 1);
    localparam int ADDR_W = $clog2(BLOCK_BYTES);
    localparam int OFF_W  = BLK_W + POS_W;
    localparam int TRY_W  = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
    localparam int TO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

    fetch_state_e state_q, state_d;

    logic [BLK_W-1:0] blk_q;
    logic [POS_W-1:0] pos_q;
    logic [LEN_W-1:0] left_q;
    logic [TRY_W-1:0] tries_q;
    logic             err_q;

    logic [POS_W-1:0] rem;
    logic [LEN_W-1:0] burst_len;
    logic [OFF_W-1:0] addr_full;
    logic             tmr_exp;
    logic             sum_zero;
    logic             attempt_rst;

    assign rem       = POS_W'(BLOCK_BYTES) - pos_q;
    assign burst_len = (rem > POS_W'(BURST_MAX)) ? LEN_W'(BURST_MAX) : LEN_W'(rem);
    assign addr_full = OFF_W'(blk_q) * OFF_W'(BLOCK_BYTES) + OFF_W'(pos_q);

    edid_fetch_timer #(.LIMIT(TO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == ST_ISSUE),
        .run     (state_q == ST_WAIT),
        .expired (tmr_exp)
    );

    edid_fetch_store #(.DEPTH(BLOCK_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sum_clr  (attempt_rst),
        .wr_en    (eng_pop),
        .wr_addr  (pos_q[ADDR_W-1:0]),
        .wr_data  (eng_rdata),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sum_zero (sum_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (eng_done)     state_d = ST_DRAIN;
                else if (tmr_exp) state_d = ST_RETRY;
            end
            ST_DRAIN: begin
                if (left_q == LEN_W'(1)) begin
                    state_d = (pos_q == POS_W'(BLOCK_BYTES - 1)) ? ST_CHECK : ST_CLEAR;
                end
            end
            ST_CHECK: state_d = sum_zero ? ST_DONE : ST_RETRY;
            ST_RETRY: state_d = (tries_q == TRY_W'(MAX_RETRY)) ? ST_DONE : ST_CLEAR;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // a new attempt starts from position 0 with an empty checksum
    assign attempt_rst = (state_q == ST_IDLE && start) ||
                         (state_q == ST_RETRY && tries_q != TRY_W'(MAX_RETRY));

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q   <= '0;
            pos_q   <= '0;
            left_q  <= '0;
            tries_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                blk_q   <= blk_idx;
                tries_q <= '0;
                err_q   <= 1'b0;
            end
            if (attempt_rst) begin
                pos_q <= '0;
            end
            if (state_q == ST_RETRY) begin
                if (tries_q == TRY_W'(MAX_RETRY)) err_q <= 1'b1;
                else                              tries_q <= tries_q + 1'b1;
            end
            if (state_q == ST_WAIT && eng_done) begin
                left_q <= burst_len;
            end
            if (state_q == ST_DRAIN) begin
                pos_q  <= pos_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        err     = err_q;
        eng_clr = (state_q == ST_CLEAR);
        eng_go  = (state_q == ST_ISSUE);
        eng_pop = (state_q == ST_DRAIN);
        eng_seg = 8'(addr_full >> 8);
        eng_off = addr_full[7:0];
        eng_len = burst_len;
    end

    // R4
    clr_before_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> $past(eng_clr));

    // R2
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> (eng_len != '0 && eng_len <= LEN_W'(BURST_MAX)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(blk_q));

    // R8
    timeout_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && tmr_exp && !eng_done) |=> (state_q == ST_RETRY));

    // R11
    pop_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_pop |-> (!eng_go && !eng_clr && $countones({eng_pop, done}) == 1));
endmodule

// File: tb/edid_fetch_seq_tb.sv
module edid_fetch_seq_tb;
    localparam int TO = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] blk_idx = '0;
    logic       busy, done, err, eng_clr, eng_go, eng_pop;
    logic [7:0] eng_seg, eng_off, rd_data;
    logic [4:0] eng_len;
    logic       eng_done = 1'b0;
    logic [7:0] eng_rdata;
    logic [6:0] rd_addr = '0;

    int n_chk = 0, n_bad = 0;
    int go_cnt = 0, pop_cnt = 0, done_cnt = 0, exp_pos = 0, exp_blk = 0;
    int delay = 3, bad_n = 0;
    bit noresp = 0, last_clr = 0, got_err;

    logic [15:0] base_q = '0;
    logic [6:0]  ptr_q = '0;
    logic        pend_q = 1'b0;
    int          cd_q = 0;

    always #4 clk = ~clk;

    edid_fetch_seq #(.CLK_HZ(1000), .TIMEOUT_MS(200)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_idx(blk_idx),
        .busy(busy), .done(done), .err(err),
        .eng_clr(eng_clr), .eng_go(eng_go), .eng_seg(eng_seg), .eng_off(eng_off),
        .eng_len(eng_len), .eng_done(eng_done), .eng_rdata(eng_rdata),
        .eng_pop(eng_pop), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] ref_byte(int b, int i);
        int s = 0;
        if (i < 127) return 8'((b * 29 + i * 11 + 3) & 255);
        for (int k = 0; k < 127; k++) s += (b * 29 + k * 11 + 3) & 255;
        return 8'((256 - (s & 255)) & 255);
    endfunction

    function automatic logic [7:0] model_data(logic [15:0] base, logic [6:0] ptr, int gcnt, int badn);
        int a = int'(base) + int'(ptr);
        logic [7:0] v = ref_byte(a / 128, a % 128);
        if ((a % 128) == 5 && gcnt > 0 && ((gcnt - 1) / 8) < badn) v = v ^ 8'h01;
        return v;
    endfunction

    assign eng_rdata = model_data(base_q, ptr_q, go_cnt, bad_n);

    // engine model
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (eng_clr) ptr_q <= '0;
        if (eng_pop) ptr_q <= ptr_q + 1'b1;
        if (eng_go) begin
            base_q <= {eng_seg, eng_off};
            pend_q <= !noresp;
            cd_q   <= delay;
        end else if (pend_q) begin
            if (cd_q == 1) begin
                eng_done <= 1'b1;
                pend_q   <= 1'b0;
            end else begin
                cd_q <= cd_q - 1;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // command monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (eng_go) begin
                chk(eng_len == 5'd16, "R2 burst length", int'(eng_len), 16);
                chk({eng_seg, eng_off} == 16'(exp_blk * 128 + exp_pos), "R3 command address",
                    int'({eng_seg, eng_off}), exp_blk * 128 + exp_pos);
                chk(last_clr, "R4 clear before command", int'(last_clr), 1);
                go_cnt++;
            end
            if (eng_pop) begin
                pop_cnt++;
                exp_pos = (exp_pos + 1) % 128;
            end
            if (done) done_cnt++;
            last_clr = eng_clr;
        end
    end

    task automatic finish_all();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: done count actual %0d expected 1", done_cnt);
        finish_all();
    end

    task automatic launch(int b, int d, bit nr, int bad);
        exp_blk = b; delay = d; noresp = nr; bad_n = bad;
        go_cnt = 0; pop_cnt = 0; done_cnt = 0; exp_pos = 0;
        @(negedge clk);
        start = 1'b1; blk_idx = 8'(b);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run();
        while (!done) @(negedge clk);
        got_err = err;
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R10 one done pulse", done_cnt, 1);
        chk(!busy, "R10 idle after done", int'(busy), 0);
    endtask

    task automatic check_store(int b);
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            rd_addr = 7'(i);
            #1;
            chk(rd_data == ref_byte(b, i), "R5 stored byte", int'(rd_data), int'(ref_byte(b, i)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, done, err, eng_clr, eng_go, eng_pop} == 6'b0, "R1 reset outputs",
            int'({busy, done, err, eng_clr, eng_go, eng_pop}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, err} == 3'b0, "R1 after reset", int'({busy, done, err}), 0);

        // R6 R5 R3: sweep of blocks and engine delays, plus top segment
        for (int b = 0; b < 9; b++) begin
            int bb = (b == 8) ? 255 : b;
            launch(bb, b + 1, 0, 0);
            finish_run();
            chk(got_err == 0, "R6 good checksum", int'(got_err), 0);
            chk(go_cnt == 8, "R2 commands per block", go_cnt, 8);
            chk(pop_cnt == 128, "R11 pops per block", pop_cnt, 128);
            check_store(bb);
        end

        // R7 checksum retries
        for (int bad = 1; bad <= 3; bad++) begin
            launch(4, 2, 0, bad);
            finish_run();
            chk(got_err == (bad == 3), "R7 error after retries", int'(got_err), int'(bad == 3));
            chk(go_cnt == 8 * ((bad == 3) ? 3 : bad + 1), "R7 attempt count",
                go_cnt, 8 * ((bad == 3) ? 3 : bad + 1));
            if (bad < 3) check_store(4);
        end

        // R8 timeouts
        launch(6, 1, 1, 0);
        finish_run();
        chk(got_err == 1, "R8 no response error", int'(got_err), 1);
        chk(go_cnt == 3, "R8 attempts on timeout", go_cnt, 3);
        chk(pop_cnt == 0, "R11 no pops on timeout", pop_cnt, 0);

        launch(7, TO - 1, 0, 0);
        finish_run();
        chk(got_err == 0, "R8 completion at last cycle", int'(got_err), 0);
        chk(go_cnt == 8, "R8 commands at limit", go_cnt, 8);

        launch(7, TO, 0, 0);
        finish_run();
        chk(got_err == 1, "R8 completion one cycle late", int'(got_err), 1);
        chk(go_cnt == 3, "R8 late attempts", go_cnt, 3);

        // R9 start while busy
        launch(3, 2, 0, 0);
        repeat (40) @(negedge clk);
        start = 1'b1; blk_idx = 8'd9;
        @(negedge clk);
        start = 1'b0;
        finish_run();
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R9 no second fetch", done_cnt, 1);
        chk(go_cnt == 8, "R9 command count", go_cnt, 8);
        chk(got_err == 0, "R9 running fetch intact", int'(got_err), 0);
        check_store(3);

        finish_all();
    end
endmodule